// File: doc/BRIEF.md
# Watchpoint Value Comparator Bank

This block holds eight programmable comparator slots that watch the values a processor produces as it runs. Each slot stores a 32-bit reference value and a small control byte. The control byte names the kind of processor event the slot watches, the relation to test, and whether the operands are signed. When an event of that kind arrives, the slot compares the event value with its reference and records the result in its own bit of a hit vector. The same block raises a one-cycle stop request on every instruction fetch while single-step mode is on.

Software reaches the sixteen slot registers through a simple synchronous register port. Addresses 0 to 7 select the value registers of slots 0 to 7. Addresses 8 to 15 select the control registers of the same slots. While the processor is held in its own reset, the block evaluates nothing and all of its results hold.

Top module: `wpt_cmp_bank`

## Requirements
- R1: A write with `reg_we` high stores `reg_wdata` at `reg_addr` on that clock edge. A value register keeps all 32 bits. A control register keeps bits [7:0] and reads back zero in bits [31:8]. `reg_rdata` holds the contents of the register at `reg_addr`, registered one cycle after the address is presented. A read in the same cycle as a write returns the older contents.
- R2: While `rst` is high at a clock edge, all registers, `hit_o`, `stop_req` and `reg_rdata` become zero.
- R3: The control byte is laid out as bit 0 = present, bits [3:1] = event kind, bits [6:4] = condition, bit 7 = signed. When a slot's present bit is clear and `cpu_rst` is low, its hit bit is zero from the following cycle onward.
- R4: Event kinds are 1 = instruction fetch address, 2 = load address, 3 = store address, 4 = load data, 5 = store data. An event is evaluated only when `ev_valid` is high and `ev_kind` is between 1 and 5. Kinds 0, 6 and 7 are not events. A present slot compares only when its kind field equals `ev_kind`.
- R5: Conditions are 1 = equal, 2 = less than, 3 = less or equal, 4 = greater than, 5 = greater or equal, 6 = not equal. In every relation the event value is on the left and the reference on the right. Conditions 0 and 7 always give a result of 0.
- R6: With the signed bit set, both operands compare as two's-complement values. With the signed bit clear, they compare as unsigned values.
- R7: On an evaluated event, each matching present slot's hit bit takes the new compare result on that edge, so both 1 and 0 overwrite the old value. The result is visible on `hit_o` one cycle after the event is presented.
- R8: A present slot whose kind differs from the current event, or that sees no event, keeps its hit bit.
- R9: When `step_mode` is high, an evaluated instruction-fetch event drives `stop_req` high for exactly the next cycle, whatever the comparators report. Otherwise `stop_req` is low.
- R10: While `cpu_rst` is high, no event is evaluated. `hit_o` holds its value and `stop_req` is low in the next cycle.
- R11: A control or value write in the same cycle as an event does not affect that event. The event uses the old settings, and the new settings apply from the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| cpu_rst | input | 1 | High while the processor is held in reset; suppresses evaluation |
| step_mode | input | 1 | Single-step mode enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-7 value, 8-15 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind code |
| ev_value | input | 32 | Event value |
| hit_o | output | 8 | Per-slot hit bits |
| stop_req | output | 1 | Single-step stop request |

## Verification
Every result of this block is registered once. A hit bit, the stop request and the read data all reflect the inputs presented one cycle earlier, and register writes first affect an event in the cycle after the write. The bench drives inputs just after the falling edge. On the rising edge, a behavioural model advances on the same inputs. At the next falling edge the bench compares `hit_o`, `stop_req` and `reg_rdata` with the model, so each result is checked in the exact cycle it falls due. Directed phases cover each relation under both signed and unsigned compares. They also cover kind mismatches, the codes that are not events, the absent-slot case, processor reset and a write colliding with an event. A pseudo-random phase follows.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_IFETCH = 3'd1,
    EV_LDADR = 3'd2,
    EV_STADR = 3'd3,
    EV_LDDAT = 3'd4,
    EV_STDAT = 3'd5
  } ev_kind_e;

  typedef enum logic [2:0] {
    REL_EQ = 3'd1,
    REL_LT = 3'd2,
    REL_LE = 3'd3,
    REL_GT = 3'd4,
    REL_GE = 3'd5,
    REL_NE = 3'd6
  } rel_e;

  // control byte: [7] signed, [6:4] condition, [3:1] kind, [0] present
  typedef struct packed {
    logic       sgn;
    logic [2:0] rel;
    logic [2:0] kind;
    logic       present;
  } slot_cfg_t;

  localparam int CFG_W = $bits(slot_cfg_t);

endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
  import wpt_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 32,
  parameter int AW    = $clog2(NSLOT) + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 rdata,
  output logic [NSLOT-1:0][DW-1:0]      ref_o,
  output slot_cfg_t [NSLOT-1:0]         cfg_o
);
  localparam int IW = AW - 1;

  logic [NSLOT-1:0][DW-1:0] val_q;
  slot_cfg_t [NSLOT-1:0]    cfg_q;
  logic [IW-1:0]            idx;
  logic                     is_cfg;

  assign idx    = addr[IW-1:0];
  assign is_cfg = addr[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      cfg_q <= '0;
      rdata <= '0;
    end else begin
      rdata <= is_cfg ? DW'(cfg_q[idx]) : val_q[idx];
      if (we) begin
        if (is_cfg) cfg_q[idx] <= slot_cfg_t'(wdata[CFG_W-1:0]);
        else        val_q[idx] <= wdata;
      end
    end
  end

  assign ref_o = val_q;
  assign cfg_o = cfg_q;

  // R1
  val_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !is_cfg) |=> (val_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/wpt_slot.sv
module wpt_slot
  import wpt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          freeze,
  input  logic          ev_go,
  input  logic [2:0]    ev_kind,
  input  logic [DW-1:0] ev_value,
  input  slot_cfg_t     cfg,
  input  logic [DW-1:0] ref_val,
  output logic          hit
);
  logic signed [DW:0] lhs, rhs;
  logic               less, same, result, sel;

  // one extra top bit: sign copy when signed, zero when unsigned
  assign lhs  = {cfg.sgn & ev_value[DW-1], ev_value};
  assign rhs  = {cfg.sgn & ref_val[DW-1], ref_val};
  assign less = lhs < rhs;
  assign same = ev_value == ref_val;
  assign sel  = ev_go && (cfg.kind == ev_kind);

  always_comb begin
    case (cfg.rel)
      REL_EQ:  result = same;
      REL_LT:  result = less;
      REL_LE:  result = less | same;
      REL_GT:  result = ~(less | same);
      REL_GE:  result = ~less;
      REL_NE:  result = ~same;
      default: result = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               hit <= 1'b0;
    else if (!freeze) begin
      if (!cfg.present)    hit <= 1'b0;
      else if (sel)        hit <= result;
    end
  end

  // R3
  absent_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.present && !freeze) |=> !hit);

  // R8
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.present && !(ev_go && cfg.kind == ev_kind)) |=> $stable(hit));

endmodule

// File: rtl/wpt_step.sv
module wpt_step
  import wpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_go,
  input  logic [2:0] ev_kind,
  input  logic       step_mode,
  output logic       stop
);
  always_ff @(posedge clk) begin
    if (rst) stop <= 1'b0;
    else     stop <= ev_go && step_mode && (ev_kind == EV_IFETCH);
  end

  // R9
  step_cause_chk: assert property (@(posedge clk) disable iff (rst)
    stop |-> ($past(step_mode) && $past(ev_kind) == EV_IFETCH && $past(ev_go)));

endmodule

// File: rtl/wpt_cmp_bank.sv
module wpt_cmp_bank
  import wpt_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 32,
  parameter int AW    = $clog2(NSLOT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_rst,
  input  logic             step_mode,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic [DW-1:0]    ev_value,
  output logic [NSLOT-1:0] hit_o,
  output logic             stop_req
);
  logic [NSLOT-1:0][DW-1:0] ref_v;
  slot_cfg_t [NSLOT-1:0]    cfg_v;
  logic                     ev_go;

  assign ev_go = ev_valid && !cpu_rst &&
                 (ev_kind >= EV_IFETCH) && (ev_kind <= EV_STDAT);

  wpt_cfg_regs #(.NSLOT(NSLOT), .DW(DW), .AW(AW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ref_o (ref_v),
    .cfg_o (cfg_v)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wpt_slot #(.DW(DW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .freeze   (cpu_rst),
      .ev_go    (ev_go),
      .ev_kind  (ev_kind),
      .ev_value (ev_value),
      .cfg      (cfg_v[s]),
      .ref_val  (ref_v[s]),
      .hit      (hit_o[s])
    );
  end

  wpt_step u_step (
    .clk       (clk),
    .rst       (rst),
    .ev_go     (ev_go),
    .ev_kind   (ev_kind),
    .step_mode (step_mode),
    .stop      (stop_req)
  );

  // R2
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (hit_o == '0 && !stop_req && reg_rdata == '0));

  // R10
  cpu_reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rst |=> ($stable(hit_o) && !stop_req));

endmodule

// File: tb/wpt_cmp_bank_tb.sv
module wpt_cmp_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rst = 1'b0, step_mode = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic [31:0] ev_value = '0;
  logic [7:0]  hit_o;
  logic        stop_req;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  wpt_cmp_bank u_dut (
    .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .step_mode(step_mode),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_value(ev_value), .hit_o(hit_o), .stop_req(stop_req)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_val [8];
  logic [7:0]  m_cfg [8];
  logic [7:0]  m_hit;
  logic        m_stop;
  logic [31:0] m_rd;

  function automatic bit relation(input int c, input bit s,
                                  input logic [31:0] a, input logic [31:0] b);
    longint x, y;
    x = s ? longint'($signed(a)) : longint'({32'd0, a});
    y = s ? longint'($signed(b)) : longint'({32'd0, b});
    case (c)
      1: return x == y;
      2: return x <  y;
      3: return x <= y;
      4: return x >  y;
      5: return x >= y;
      6: return x != y;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_cfg[i] = 0; end
      m_hit = 0; m_stop = 0; m_rd = 0;
    end else begin
      bit evald;
      evald = ev_valid && !cpu_rst && ev_kind >= 1 && ev_kind <= 5;
      if (!cpu_rst)
        for (int i = 0; i < 8; i++) begin
          if (!m_cfg[i][0]) m_hit[i] = 0;
          else if (evald && m_cfg[i][3:1] == ev_kind)
            m_hit[i] = relation(int'(m_cfg[i][6:4]), m_cfg[i][7], ev_value, m_val[i]);
        end
      m_stop = evald && step_mode && ev_kind == 1;
      m_rd = reg_addr[3] ? {24'd0, m_cfg[reg_addr[2:0]]} : m_val[reg_addr[2:0]];
      if (reg_we) begin
        if (reg_addr[3]) m_cfg[reg_addr[2:0]] = reg_wdata[7:0];
        else             m_val[reg_addr[2:0]] = reg_wdata;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      checks += 3;
      if (hit_o !== m_hit) begin
        fails++;
        $display("FAIL %s hit_o: actual %b expected %b", tag, hit_o, m_hit);
      end
      if (stop_req !== m_stop) begin
        fails++;
        $display("FAIL %s stop_req: actual %b expected %b", tag, stop_req, m_stop);
      end
      if (reg_rdata !== m_rd) begin
        fails++;
        $display("FAIL %s reg_rdata: actual %h expected %h", tag, reg_rdata, m_rd);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input bit we, input logic [3:0] a, input logic [31:0] d,
                      input bit v, input logic [2:0] k, input logic [31:0] x);
    reg_we = we; reg_addr = a; reg_wdata = d;
    ev_valid = v; ev_kind = k; ev_value = x;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    tick(1, a, d, 0, 0, 0);
  endtask

  task automatic ev(input logic [2:0] k, input logic [31:0] x);
    tick(0, 0, 0, 1, k, x);
  endtask

  function automatic logic [31:0] cb(input bit s, input int c, input int k, input bit p);
    return {24'd0, s, 3'(c), 3'(k), p};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    // R2: reset state
    tag = "R2";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick(0, 0, 0, 0, 0, 0);

    // R1: write and read back every register
    tag = "R1";
    for (int i = 0; i < 8; i++) wr(4'(i), 32'hA5000000 + 32'(i * 32'h1111));
    for (int i = 0; i < 8; i++) wr(4'(8 + i), 32'hFFFFFF00 | 32'(i * 3));
    for (int i = 0; i < 16; i++) tick(0, 4'(i), 0, 0, 0, 0);
    tick(1, 4'd2, 32'hDEADBEEF, 0, 0, 0);     // read same cycle as write: old data
    tick(0, 4'd2, 0, 0, 0, 0);

    // configure slots
    tag = "R5";
    wr(4'd0, 32'h100);      wr(4'd8,  cb(0, 1, 1, 1));   // fetch EQ unsigned
    wr(4'd1, 32'h8000);     wr(4'd9,  cb(0, 2, 2, 1));   // load addr LT
    wr(4'd2, 32'hFFFFFFF0); wr(4'd10, cb(1, 5, 3, 1));   // store addr GE signed
    wr(4'd3, 32'hFFFFFFF0); wr(4'd11, cb(1, 4, 4, 1));   // load data GT signed
    wr(4'd4, 32'hFFFFFFF0); wr(4'd12, cb(0, 4, 4, 1));   // load data GT unsigned
    wr(4'd5, 32'd7);        wr(4'd13, cb(0, 6, 5, 1));   // store data NE
    wr(4'd6, 32'h200);      wr(4'd14, cb(0, 3, 1, 1));   // fetch LE
    wr(4'd7, 32'h100);      wr(4'd15, cb(0, 1, 1, 0));   // absent

    // R4 / R5: kinds and relations
    tag = "R4";
    ev(1, 32'h100); ev(1, 32'h200); ev(1, 32'h201);
    ev(2, 32'h7FFF); ev(2, 32'h8000);
    ev(3, 32'hFFFFFFF0); ev(3, 32'hFFFFFFEF); ev(3, 32'h5);
    ev(5, 32'd7); ev(5, 32'd8);
    ev(0, 32'h100); ev(6, 32'h100); ev(7, 32'h100);
    tick(0, 0, 0, 0, 1, 32'h0);                 // kind without strobe
    // R6: signed versus unsigned
    tag = "R6";
    ev(4, 32'd5); ev(4, 32'hFFFFFFF8); ev(4, 32'h80000000); ev(4, 32'hFFFFFFF0);
    // R7: non-sticky overwrite
    tag = "R7";
    ev(1, 32'h100); ev(1, 32'h300); ev(1, 32'h100);
    // R8: other kinds leave slot 0 alone
    tag = "R8";
    ev(2, 32'h100); ev(5, 32'h0); tick(0, 0, 0, 0, 0, 0);
    // R5: conditions 0 and 7 never hit
    tag = "R5";
    wr(4'd8, cb(0, 0, 1, 1)); ev(1, 32'h100);
    wr(4'd8, cb(0, 7, 1, 1)); ev(1, 32'h100);
    wr(4'd8, cb(0, 1, 1, 1)); ev(1, 32'h100);
    // R3: absent slot clears
    tag = "R3";
    wr(4'd15, cb(0, 1, 1, 1)); ev(1, 32'h100);
    wr(4'd15, cb(0, 1, 1, 0)); tick(0, 0, 0, 0, 0, 0); ev(1, 32'h100);
    // R9: single step
    tag = "R9";
    step_mode = 1; ev(1, 32'h999); ev(2, 32'h0); ev(1, 32'h100);
    tick(0, 0, 0, 0, 0, 0); step_mode = 0; ev(1, 32'h100);
    // R10: processor reset freezes everything
    tag = "R10";
    cpu_rst = 1; step_mode = 1;
    ev(1, 32'h300); ev(2, 32'h0); wr(4'd8, cb(0, 1, 1, 0)); ev(1, 32'h300);
    cpu_rst = 0; step_mode = 0;
    ev(1, 32'h300);
    wr(4'd8, cb(0, 1, 1, 1));
    // R11: write in the same cycle as an event
    tag = "R11";
    tick(1, 4'd8, cb(0, 6, 1, 1), 1, 1, 32'h100);  // old EQ applies: hit
    ev(1, 32'h100);                                // new NE applies: no hit
    tick(1, 4'd0, 32'h555, 1, 1, 32'h555);         // old value 0x100 used: NE hit
    ev(1, 32'h555);

    // pseudo-random phase
    tag = "R7";
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      step_mode = lfsr[3];
      cpu_rst   = (lfsr[7:4] == 4'd0);
      if (lfsr[9:8] == 2'd0)
        tick(1, lfsr[13:10], {lfsr[31:24], 20'd0, lfsr[27:24]}, lfsr[14], 3'(lfsr[17:15]), {28'd0, lfsr[21:18]});
      else
        tick(0, lfsr[13:10], 0, lfsr[14] | lfsr[22], 3'(lfsr[17:15]),
             lfsr[23] ? {lfsr[31:24], 24'd0} : {28'd0, lfsr[21:18]});
    end
    cpu_rst = 0; step_mode = 0;
    tick(0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule